// File: doc/BRIEF.md
# Cross-trigger interface unit

This block sits beside one processor and turns debug events into trigger requests. Local trigger inputs, such as a "core halted" flag or a performance-monitor interrupt, can be steered onto a small set of event channels. Events on those channels can be steered onto trigger outputs, such as a halt request or a restart request. Software can also raise a channel event directly by writing a register, and can clear a pending output trigger by writing an acknowledge.

Each channel has a gate bit. When the gate is open, local events on that channel leave the unit on a parallel channel bus toward a shared channel matrix, and events that the matrix returns on that channel are accepted. When the gate is closed, the channel stays private to this unit. Several units that share the matrix can therefore halt or restart several processors in the same clock cycle from one software pulse.

Output triggers are latched. A trigger stays high from the clock edge after its causing event until software acknowledges it. A status register shows which triggers are still high, so software can poll for the clear before it raises the next request. The default build has four channels, eight trigger inputs and eight trigger outputs, and uses a 32-bit register bus with combinational read data.

Top module: `xtrig_unit`

## Requirements
- R1: Register map on word-aligned byte offsets: 0x000 control (bit 0 = unit enable, read/write). 0x010 acknowledge (write-only). 0x01C software pulse (write-only). 0x020+4n input map for trigger input n. 0x0A0+4n output map for trigger output n. 0x134 trigger status (read-only). 0x140 channel gate. Map and gate registers hold only the low NUM_CHAN bits. Reads of write-only registers, of unimplemented offsets and of unused bits return zero.
- R2: While control bit 0 is 0, the unit drives no channel event onto its channel bus and sets no output trigger, whether the event comes from a pulse, a trigger input or the matrix.
- R3: Writing 1 to bit c of the pulse register, with the unit enabled, raises an event on channel c for the single cycle of the write.
- R4: While trigger input n is high, each channel c whose bit is set in input map n carries an event in that cycle.
- R5: An event on channel c, from a local source or from the matrix through an open gate, sets output trigger n at the next clock edge when bit c of output map n is 1.
- R6: Gate bit c clear keeps channel c local: local events on c do not appear on the outgoing channel bus, and incoming matrix events on c are ignored. Gate bit c set does both.
- R7: An output trigger stays high until 1 is written to its bit of the acknowledge register, and it goes low at the clock edge that ends that write. Status bit n reads 1 exactly while output trigger n is high.
- R8: When an acknowledge and a new setting event for the same output trigger fall in the same cycle, the trigger stays high.
- R9: With two units sharing the matrix (each incoming bus is the OR of the outgoing buses), a pulse on an open-gated channel of one unit sets the mapped output triggers of both units at the same clock edge.
- R10: After reset, all registers read zero, all output triggers are low and the outgoing channel bus is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte address |
| busWrite | input | 1 | Write enable for the addressed register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| trigIn | input | NUM_TRIG | Local trigger inputs |
| trigOut | output | NUM_TRIG | Latched output triggers |
| chanIn | input | NUM_CHAN | Channel events arriving from the shared matrix |
| chanOut | output | NUM_CHAN | Channel events sent to the shared matrix |

## Verification
The hardest case to reach is the acknowledge that collides with a new setting event for the same trigger. The register bus carries only one write per cycle, so a software pulse cannot be issued together with the acknowledge. The bench raises the event through a mapped trigger input, which it holds high during the acknowledge write, and then checks that the trigger is still set. Matrix behaviour needs a second unit, so the bench wires two instances through an OR of their channel buses. It checks gate-open propagation, the case where a closed gate rejects incoming events, and the case where a disabled unit rejects them.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

  // Width of the register-slot index carried in the strobe struct (up to 32 triggers)
  localparam int XT_IDX_W = 5;

  // Byte offsets of the register map
  localparam int OFF_CTRL   = 32'h000;
  localparam int OFF_ACK    = 32'h010;
  localparam int OFF_PULSE  = 32'h01C;
  localparam int OFF_INMAP  = 32'h020;
  localparam int OFF_OUTMAP = 32'h0A0;
  localparam int OFF_STATUS = 32'h134;
  localparam int OFF_GATE   = 32'h140;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_INMAP,
    RD_OUTMAP,
    RD_STATUS,
    RD_GATE
  } rdsel_e;

  typedef struct packed {
    logic                wrCtrl;
    logic                wrAck;
    logic                wrPulse;
    logic                wrGate;
    logic                wrInMap;
    logic                wrOutMap;
    logic [XT_IDX_W-1:0] idx;
    rdsel_e              rdSel;
  } xt_strobe_t;

endpackage

// File: rtl/xtrig_ctrl.sv
module xtrig_ctrl
  import xtrig_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output xt_strobe_t        st
);

  localparam int TRIG_SPAN = NUM_TRIG * 4;

  logic [31:0] addrInt;
  logic        aligned;

  assign addrInt = 32'(busAddr);
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    st       = '0;
    st.rdSel = RD_NONE;
    if (aligned) begin
      if (addrInt == OFF_CTRL) begin
        st.wrCtrl = busWrite;
        st.rdSel  = RD_CTRL;
      end else if (addrInt == OFF_ACK) begin
        st.wrAck = busWrite;
      end else if (addrInt == OFF_PULSE) begin
        st.wrPulse = busWrite;
      end else if (addrInt >= OFF_INMAP && addrInt < OFF_INMAP + TRIG_SPAN) begin
        st.wrInMap = busWrite;
        st.rdSel   = RD_INMAP;
        st.idx     = XT_IDX_W'((addrInt - OFF_INMAP) >> 2);
      end else if (addrInt >= OFF_OUTMAP && addrInt < OFF_OUTMAP + TRIG_SPAN) begin
        st.wrOutMap = busWrite;
        st.rdSel    = RD_OUTMAP;
        st.idx      = XT_IDX_W'((addrInt - OFF_OUTMAP) >> 2);
      end else if (addrInt == OFF_STATUS) begin
        st.rdSel = RD_STATUS;
      end else if (addrInt == OFF_GATE) begin
        st.wrGate = busWrite;
        st.rdSel  = RD_GATE;
      end
    end
  end

  // R1: a bus cycle targets at most one register
  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrCtrl, st.wrAck, st.wrPulse, st.wrGate, st.wrInMap, st.wrOutMap}));

  // R1: no strobe without a write
  assert_strobe_needs_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |-> !(st.wrCtrl || st.wrAck || st.wrPulse || st.wrGate || st.wrInMap || st.wrOutMap));

endmodule

// File: rtl/xtrig_datapath.sv
module xtrig_datapath
  import xtrig_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int NUM_TRIG = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  xt_strobe_t          st,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_TRIG-1:0] trigIn,
  output logic [NUM_TRIG-1:0] trigOut,
  input  logic [NUM_CHAN-1:0] chanIn,
  output logic [NUM_CHAN-1:0] chanOut
);

  logic                ctrlEn;
  logic [NUM_CHAN-1:0] gateReg;
  logic [NUM_CHAN-1:0] inMap  [NUM_TRIG];
  logic [NUM_CHAN-1:0] outMap [NUM_TRIG];
  logic [NUM_TRIG-1:0] trigLat;

  logic [NUM_CHAN-1:0] swPulse;
  logic [NUM_CHAN-1:0] fromInputs;
  logic [NUM_CHAN-1:0] localChan;
  logic [NUM_CHAN-1:0] allChan;
  logic [NUM_TRIG-1:0] hit;
  logic [NUM_TRIG-1:0] ackMask;
  logic                unusedWdata;

  assign unusedWdata = ^busWdata;

  // Channel event sources
  assign swPulse = (st.wrPulse && ctrlEn) ? busWdata[NUM_CHAN-1:0] : '0;

  always_comb begin
    fromInputs = '0;
    for (int n = 0; n < NUM_TRIG; n++) begin
      if (trigIn[n]) fromInputs = fromInputs | inMap[n];
    end
  end

  assign localChan = ctrlEn ? (swPulse | fromInputs) : '0;
  assign chanOut   = localChan & gateReg;
  assign allChan   = localChan | (ctrlEn ? (chanIn & gateReg) : '0);
  assign ackMask   = st.wrAck ? busWdata[NUM_TRIG-1:0] : '0;

  // Output mapping, one comparator per trigger
  for (genvar n = 0; n < NUM_TRIG; n++) begin : g_hit
    assign hit[n] = ctrlEn && (|(allChan & outMap[n]));
  end

  // Register file and trigger latches; a set beats an acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      gateReg <= '0;
      trigLat <= '0;
      for (int n = 0; n < NUM_TRIG; n++) begin
        inMap[n]  <= '0;
        outMap[n] <= '0;
      end
    end else begin
      trigLat <= hit | (trigLat & ~ackMask);
      if (st.wrCtrl) ctrlEn  <= busWdata[0];
      if (st.wrGate) gateReg <= busWdata[NUM_CHAN-1:0];
      for (int n = 0; n < NUM_TRIG; n++) begin
        if (st.idx == XT_IDX_W'(n)) begin
          if (st.wrInMap)  inMap[n]  <= busWdata[NUM_CHAN-1:0];
          if (st.wrOutMap) outMap[n] <= busWdata[NUM_CHAN-1:0];
        end
      end
    end
  end

  assign trigOut = trigLat;

  // Read mux
  always_comb begin
    busRdata = '0;
    case (st.rdSel)
      RD_CTRL:   busRdata = {31'b0, ctrlEn};
      RD_STATUS: busRdata = 32'(trigLat);
      RD_GATE:   busRdata = 32'(gateReg);
      RD_INMAP: begin
        for (int n = 0; n < NUM_TRIG; n++)
          if (st.idx == XT_IDX_W'(n)) busRdata = 32'(inMap[n]);
      end
      RD_OUTMAP: begin
        for (int n = 0; n < NUM_TRIG; n++)
          if (st.idx == XT_IDX_W'(n)) busRdata = 32'(outMap[n]);
      end
      default:   busRdata = '0;
    endcase
  end

  // R2: a disabled unit puts nothing on the matrix
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |-> (chanOut == '0));

  // R3: a software pulse on an open-gated channel appears on the outgoing bus in the write cycle
  assert_pulse_seen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrPulse && ctrlEn) |-> ((busWdata[NUM_CHAN-1:0] & gateReg & ~chanOut) == '0));

  for (genvar n = 0; n < NUM_TRIG; n++) begin : g_chk
    // R7: a trigger only drops after an acknowledge of its bit
    assert_fall_needs_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(trigLat[n]) |-> $past(st.wrAck && busWdata[n]));

    // R2: a trigger only rises while the unit is enabled
    assert_rise_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(trigLat[n]) |-> $past(ctrlEn));

    // R5: a gated matrix event on a mapped channel sets the trigger next cycle
    assert_matrix_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlEn && (|(chanIn & gateReg & outMap[n]))) |=> trigLat[n]);
  end

endmodule

// File: rtl/xtrig_unit.sv
module xtrig_unit
  import xtrig_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int NUM_TRIG = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_TRIG-1:0] trigIn,
  output logic [NUM_TRIG-1:0] trigOut,
  input  logic [NUM_CHAN-1:0] chanIn,
  output logic [NUM_CHAN-1:0] chanOut
);

  xt_strobe_t strobes;

  xtrig_ctrl #(
    .NUM_TRIG(NUM_TRIG),
    .ADDR_W  (ADDR_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrite(busWrite),
    .st      (strobes)
  );

  xtrig_datapath #(
    .NUM_CHAN(NUM_CHAN),
    .NUM_TRIG(NUM_TRIG)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .st      (strobes),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .trigIn  (trigIn),
    .trigOut (trigOut),
    .chanIn  (chanIn),
    .chanOut (chanOut)
  );

endmodule

// File: tb/sim_xtrig_unit.sv
`timescale 1ns/1ps
module sim_xtrig_unit;

  localparam logic [11:0] A_CTRL   = 12'h000;
  localparam logic [11:0] A_ACK    = 12'h010;
  localparam logic [11:0] A_PULSE  = 12'h01C;
  localparam logic [11:0] A_INMAP  = 12'h020;
  localparam logic [11:0] A_OUTMAP = 12'h0A0;
  localparam logic [11:0] A_STATUS = 12'h134;
  localparam logic [11:0] A_GATE   = 12'h140;

  localparam int K_RD = 0;
  localparam int K_TRIG = 1;
  localparam int K_CHAN = 2;

  typedef struct {
    int          kind;
    int          unit;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [11:0] bAddr [2];
  logic        bWr   [2];
  logic [31:0] bWd   [2];
  logic [31:0] bRd   [2];
  logic [7:0]  tIn   [2];
  logic [7:0]  tOut  [2];
  logic [3:0]  cOut  [2];
  logic [3:0]  mtx;

  assign mtx = cOut[0] | cOut[1];

  xtrig_unit u0 (
    .clk(clk), .rstN(rstN), .busAddr(bAddr[0]), .busWrite(bWr[0]), .busWdata(bWd[0]),
    .busRdata(bRd[0]), .trigIn(tIn[0]), .trigOut(tOut[0]), .chanIn(mtx), .chanOut(cOut[0]));

  xtrig_unit u1 (
    .clk(clk), .rstN(rstN), .busAddr(bAddr[1]), .busWrite(bWr[1]), .busWdata(bWd[1]),
    .busRdata(bRd[1]), .trigIn(tIn[1]), .trigOut(tOut[1]), .chanIn(mtx), .chanOut(cOut[1]));

  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_RD:    act = bRd[it.unit];
          K_TRIG:  act = 32'(tOut[it.unit]);
          default: act = 32'(cOut[it.unit]);
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s unit%0d kind%0d actual %h expected %h", it.req, it.unit, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expectv(int kind, int u, logic [31:0] e, string r);
    item_t it;
    it.kind = kind; it.unit = u; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic wr(int u, logic [11:0] a, logic [31:0] d);
    bAddr[u] = a; bWr[u] = 1'b1; bWd[u] = d;
    step();
    bWr[u] = 1'b0;
  endtask

  task automatic rd(int u, logic [11:0] a, logic [31:0] e, string r);
    bAddr[u] = a; bWr[u] = 1'b0;
    expectv(K_RD, u, e, r);
    step();
  endtask

  task automatic pulse(int u, logic [31:0] d, logic [3:0] expChan, string r);
    bAddr[u] = A_PULSE; bWr[u] = 1'b1; bWd[u] = d;
    expectv(K_CHAN, u, 32'(expChan), r);
    step();
    bWr[u] = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected finished");
      summary();
    end
  end

  // Driver
  initial begin
    for (int u = 0; u < 2; u++) begin
      bAddr[u] = '0; bWr[u] = 1'b0; bWd[u] = '0; tIn[u] = '0;
    end
    repeat (3) step();
    rstN = 1'b1;

    // R10 reset state
    expectv(K_TRIG, 0, 0, "R10");
    expectv(K_CHAN, 0, 0, "R10");
    rd(0, A_CTRL, 0, "R10");
    rd(0, A_STATUS, 0, "R10");
    rd(0, A_GATE, 0, "R10");

    // R1 register map
    wr(0, A_OUTMAP, 32'h4);
    rd(0, A_OUTMAP, 32'h4, "R1");
    wr(0, A_INMAP + 12'h0C, 32'h2);
    rd(0, A_INMAP + 12'h0C, 32'h2, "R1");
    wr(0, A_OUTMAP + 12'h04, 32'hFF);
    rd(0, A_OUTMAP + 12'h04, 32'h0F, "R1");
    wr(0, A_OUTMAP + 12'h04, 32'h0);
    wr(0, 12'h1C0, 32'hFFFF_FFFF);
    rd(0, 12'h1C0, 0, "R1");
    rd(0, A_OUTMAP + 12'h20, 0, "R1");
    rd(0, A_ACK, 0, "R1");
    rd(0, A_PULSE, 0, "R1");

    // R2 disabled unit
    wr(0, A_GATE, 32'h4);
    pulse(0, 32'h4, 4'h0, "R2");
    expectv(K_TRIG, 0, 0, "R2");
    tIn[0] = 8'h08;
    expectv(K_CHAN, 0, 0, "R2");
    step();
    tIn[0] = 8'h00;
    expectv(K_TRIG, 0, 0, "R2");

    // Enable, close gates
    wr(0, A_CTRL, 32'h1);
    rd(0, A_CTRL, 32'h1, "R1");
    wr(0, A_GATE, 32'h0);

    // R5/R6/R7 local pulse with closed gate, latch, status, ack
    pulse(0, 32'h4, 4'h0, "R6");
    expectv(K_TRIG, 0, 32'h01, "R5");
    step();
    expectv(K_TRIG, 0, 32'h01, "R7");
    rd(0, A_STATUS, 32'h01, "R7");
    wr(0, A_ACK, 32'h1);
    expectv(K_TRIG, 0, 0, "R7");
    rd(0, A_STATUS, 0, "R7");

    // R3 pulse with open gate lasts one cycle
    wr(0, A_GATE, 32'h4);
    pulse(0, 32'h4, 4'h4, "R3");
    expectv(K_TRIG, 0, 32'h01, "R3");
    expectv(K_CHAN, 0, 0, "R3");
    wr(0, A_ACK, 32'h1);
    expectv(K_TRIG, 0, 0, "R7");

    // R4 trigger input mapping
    wr(0, A_OUTMAP + 12'h14, 32'h2);
    wr(0, A_GATE, 32'h6);
    tIn[0] = 8'h08;
    expectv(K_CHAN, 0, 32'h2, "R4");
    step();
    tIn[0] = 8'h00;
    expectv(K_TRIG, 0, 32'h20, "R4");
    tIn[0] = 8'h04;
    expectv(K_CHAN, 0, 0, "R4");
    step();
    tIn[0] = 8'h00;
    expectv(K_TRIG, 0, 32'h20, "R4");
    wr(0, A_ACK, 32'h20);
    expectv(K_TRIG, 0, 0, "R7");

    // R8 acknowledge collides with a new event
    wr(0, A_OUTMAP, 32'h6);
    pulse(0, 32'h4, 4'h4, "R3");
    expectv(K_TRIG, 0, 32'h01, "R5");
    tIn[0] = 8'h08;
    wr(0, A_ACK, 32'h1);
    tIn[0] = 8'h00;
    expectv(K_TRIG, 0, 32'h21, "R8");
    wr(0, A_ACK, 32'h21);
    expectv(K_TRIG, 0, 0, "R7");

    // R9 shared matrix
    wr(1, A_CTRL, 32'h1);
    wr(1, A_GATE, 32'h4);
    wr(1, A_OUTMAP, 32'h4);
    wr(0, A_GATE, 32'h4);
    pulse(0, 32'h4, 4'h4, "R9");
    expectv(K_TRIG, 0, 32'h01, "R9");
    expectv(K_TRIG, 1, 32'h01, "R9");
    wr(0, A_ACK, 32'h1);
    wr(1, A_ACK, 32'h1);
    expectv(K_TRIG, 0, 0, "R7");
    expectv(K_TRIG, 1, 0, "R7");

    // R6 closed gate ignores matrix input
    wr(0, A_GATE, 32'h0);
    pulse(1, 32'h4, 4'h4, "R9");
    expectv(K_TRIG, 1, 32'h01, "R9");
    expectv(K_TRIG, 0, 0, "R6");
    wr(1, A_ACK, 32'h1);

    // R2 disabled unit ignores matrix input
    wr(0, A_GATE, 32'h4);
    wr(0, A_CTRL, 32'h0);
    pulse(1, 32'h4, 4'h4, "R9");
    expectv(K_TRIG, 1, 32'h01, "R9");
    expectv(K_TRIG, 0, 0, "R2");
    wr(1, A_ACK, 32'h1);
    expectv(K_TRIG, 1, 0, "R7");

    repeat (3) step();
    done = 1;
    summary();
  end

endmodule